// File: doc/BRIEF.md
# Two-Phase Modular Fibonacci Word Scrambler

This block scrambles a stream of 18-bit words. It holds two coupled accumulators, called the left and right lanes, and steps a Fibonacci-like recurrence over them. All arithmetic is modulo a constant slightly below 2^18, which is 258114 by default. Each accepted word takes two clock cycles.

In the first cycle (accumulate) the left lane becomes `word + right + left_carry` and the right lane becomes `left + right + right_carry`, both from the old values. In the second cycle (reduce) each lane adds the adjustment constant `2^18 - modulus`. Bit 18 of that sum becomes the lane's carry for the next word. When the bit is set, the lane also takes the low 18 bits of the adjusted sum.

The scrambled word is the left lane after reduction. One pair of 19-bit adders does the work of both cycles. Operand multiplexers, driven by the phase, choose between the lane registers and the adjustment constant.

Top module: `modfib_scrambler`

## Requirements
- R1: While `rst` is high at a rising edge, the lanes are set to their seeds: left to 56247 and right to 111981. Both carries are cleared and the block returns to the accumulate phase. After the edge, `in_ready` is 1 and `out_valid` is 0.
- R2: A word is accepted at an edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 exactly in the accumulate phase. After an acceptance it is 0 for one cycle, the reduce cycle, and then 1 again.
- R3: `out_valid` rises for exactly one cycle. This is the cycle after the reduce cycle, two edges after the accepting edge. Back-to-back words therefore give one output every two cycles.
- R4: In the accumulate cycle, new left = word + old right + left carry, and new right = old left + old right + right carry. Both use the values from before the cycle.
- R5: In the reduce cycle, each lane forms lane + (2^18 − modulus). Bit 18 of that sum becomes the lane carry. If bit 18 is 1, the lane takes the low 18 bits of the sum; otherwise the lane is unchanged. `out_data` is always below the modulus when `out_valid` is 1.
- R6: The carries made in one word's reduce cycle are the carry inputs of the next word's accumulate cycle. The scrambled sequence depends on every earlier word.
- R7: While `in_ready` is 1 and `in_valid` is 0, the lanes and carries are held. `out_data` stays stable and `out_valid` stays 0.
- R8: `in_data` is ignored whenever it is not accepted. Any value may be present while `in_valid` is 0.
- R9: Every accepted word must be below the modulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A message word is offered |
| in_data | input | 18 | Message word, below the modulus |
| in_ready | output | 1 | The block is in its accumulate phase and takes a word |
| out_valid | output | 1 | One-cycle strobe: `out_data` holds a new scrambled word |
| out_data | output | 18 | Left lane value, the scrambled word |

## Verification
The bench builds the block with its default parameters: width 18, modulus 258114 and the two default seeds. With these values the adjustment constant is 4030. The words include 0, the modulus minus one, and long runs of large values, so both the reducing and the keeping branch of each lane occur often. Carries then pass from word to word, and a reference recurrence in the bench follows the whole scrambled sequence through idle gaps, unaccepted input values and a reset partway through the stream.

// File: rtl/modfib_pkg.sv
package modfib_pkg;

   typedef enum logic {
      PH_ACC = 1'b0,
      PH_RED = 1'b1
   } phase_e;

   localparam int unsigned LANES = 2;

endpackage

// File: rtl/modfib_phase_ctrl.sv
module modfib_phase_ctrl
   import modfib_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   in_valid,
   output phase_e phase,
   output logic   take,
   output logic   done
);

   phase_e phase_q;

   assign phase = phase_q;
   assign take  = (phase_q == PH_ACC) && in_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_ACC;
         done    <= 1'b0;
      end else begin
         done <= (phase_q == PH_RED);
         unique case (phase_q)
            PH_ACC:  if (in_valid) phase_q <= PH_RED;
            PH_RED:  phase_q <= PH_ACC;
            default: phase_q <= PH_ACC;
         endcase
      end
   end

endmodule

// File: rtl/modfib_lane.sv
module modfib_lane
   import modfib_pkg::*;
#(
   parameter int unsigned W   = 18,
   parameter int unsigned ADJ = 4030
) (
   input  phase_e       phase,
   input  logic [W:0]   acc_a,
   input  logic [W:0]   acc_b,
   input  logic [W:0]   red_a,
   input  logic         cin,
   output logic [W:0]   sum
);

   localparam logic [W:0] ADJ_V = (W+1)'(ADJ);

   logic [W:0] op_a;
   logic [W:0] op_b;
   logic       op_c;

   always_comb begin
      if (phase == PH_ACC) begin
         op_a = acc_a;
         op_b = acc_b;
         op_c = cin;
      end else begin
         op_a = red_a;
         op_b = ADJ_V;
         op_c = 1'b0;
      end
      sum = op_a + op_b + {{W{1'b0}}, op_c};
   end

endmodule

// File: rtl/modfib_acc_reg.sv
module modfib_acc_reg
   import modfib_pkg::*;
#(
   parameter int unsigned W    = 18,
   parameter int unsigned SEED = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  phase_e       phase,
   input  logic         take,
   input  logic [W:0]   sum,
   output logic [W:0]   val_q,
   output logic         carry_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         val_q   <= (W+1)'(SEED);
         carry_q <= 1'b0;
      end else if (take) begin
         val_q <= sum;
      end else if (phase == PH_RED) begin
         carry_q <= sum[W];
         if (sum[W]) val_q <= {1'b0, sum[W-1:0]};
      end
   end

endmodule

// File: rtl/modfib_scrambler.sv
module modfib_scrambler
   import modfib_pkg::*;
#(
   parameter int unsigned W       = 18,
   parameter int unsigned MODULUS = 258114,
   parameter int unsigned SEED_L  = 56247,
   parameter int unsigned SEED_R  = 111981
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           in_valid,
   input  logic [W-1:0]   in_data,
   output logic           in_ready,
   output logic           out_valid,
   output logic [W-1:0]   out_data
);

   localparam int unsigned ADJ = (1 << W) - MODULUS;

   if (W < 2 || W > 30)
      $error("modfib_scrambler: W out of range");
   if (MODULUS < 2 || MODULUS >= (1 << W))
      $error("modfib_scrambler: MODULUS must lie below 2**W");
   if (SEED_L >= MODULUS || SEED_R >= MODULUS)
      $error("modfib_scrambler: seeds must lie below MODULUS");

   phase_e     phase;
   logic       take;
   logic [W:0] lane_q   [LANES];
   logic       lane_c   [LANES];
   logic [W:0] lane_sum [LANES];

   modfib_phase_ctrl u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .phase    (phase),
      .take     (take),
      .done     (out_valid)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int unsigned SEED = (g == 0) ? SEED_L : SEED_R;
      logic [W:0] acc_a;

      if (g == 0) begin : g_left
         assign acc_a = {1'b0, in_data};
      end else begin : g_right
         assign acc_a = lane_q[0];
      end

      modfib_lane #(.W(W), .ADJ(ADJ)) u_add (
         .phase (phase),
         .acc_a (acc_a),
         .acc_b (lane_q[1]),
         .red_a (lane_q[g]),
         .cin   (lane_c[g]),
         .sum   (lane_sum[g])
      );

      modfib_acc_reg #(.W(W), .SEED(SEED)) u_reg (
         .clk     (clk),
         .rst     (rst),
         .phase   (phase),
         .take    (take),
         .sum     (lane_sum[g]),
         .val_q   (lane_q[g]),
         .carry_q (lane_c[g])
      );
   end

   assign in_ready = (phase == PH_ACC);
   assign out_data = lane_q[0][W-1:0];

endmodule

// File: rtl/modfib_scrambler_chk.sv
module modfib_scrambler_chk #(
   parameter int unsigned W       = 18,
   parameter int unsigned MODULUS = 258114
) (
   input logic           clk,
   input logic           rst,
   input logic           in_valid,
   input logic [W-1:0]   in_data,
   input logic           in_ready,
   input logic           out_valid,
   input logic [W-1:0]   out_data
);

   localparam logic [W-1:0] MOD_V = W'(MODULUS);

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (in_ready && !out_valid));

   // R2
   ready_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !in_ready ##1 in_ready);

   // R3
   valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !out_valid ##1 out_valid);

   // R3
   valid_single_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   // R5
   out_below_mod_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_data < MOD_V));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (in_ready && !in_valid) |=> ($stable(out_data) && !out_valid));

   // R9
   in_below_mod_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |-> (in_data < MOD_V));

endmodule

bind modfib_scrambler modfib_scrambler_chk #(.W(W), .MODULUS(MODULUS)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/modfib_scrambler_test.sv
`timescale 1ns/1ps
module modfib_scrambler_test;

   localparam int W   = 18;
   localparam int M   = 258114;
   localparam int ADJ = (1 << W) - M;
   localparam int MASK = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic         in_ready;
   logic         out_valid;
   logic [W-1:0] out_data;

   int checks = 0;
   int fails  = 0;
   int ml, mr, mcl, mcr;

   always #2.5 clk = ~clk;

   modfib_scrambler uut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic void model_reset();
      ml = 56247; mr = 111981; mcl = 0; mcr = 0;
   endfunction

   function automatic int model_step(input int w);
      int nl, nr, tl, tr;
      nl = w + mr + mcl;
      nr = ml + mr + mcr;
      tl = nl + ADJ;
      tr = nr + ADJ;
      mcl = (tl >> W) & 1;
      mcr = (tr >> W) & 1;
      ml = (mcl != 0) ? (tl & MASK) : nl;
      mr = (mcr != 0) ? (tr & MASK) : nr;
      return ml;
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic send(input int w, input string req);
      int exp;
      check("R2 ready before word", int'(in_ready), 1);
      in_valid = 1'b1;
      in_data  = W'(w);
      tick();
      check("R2 ready low in reduce cycle", int'(in_ready), 0);
      check("R3 no strobe in reduce cycle", int'(out_valid), 0);
      in_valid = 1'b0;
      in_data  = W'($urandom);
      tick();
      exp = model_step(w);
      check("R3 strobe after reduce", int'(out_valid), 1);
      check(req, int'(out_data), exp);
      check("R5 output below modulus", int'(out_data < W'(M)), 1);
   endtask

   task automatic idle(input int n);
      int held;
      held = int'(out_data);
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b0;
         in_data  = W'($urandom);
         tick();
         check("R7 idle no strobe", int'(out_valid), 0);
         check("R7 idle output held", int'(out_data), held);
         check("R2 idle ready", int'(in_ready), 1);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      rst = 1'b1;
      tick(); tick();
      rst = 1'b0;
      check("R1 ready after reset", int'(in_ready), 1);
      check("R1 no strobe after reset", int'(out_valid), 0);
      check("R1 left seed visible", int'(out_data), 56247);

      // R4 first word from seeds
      send(0, "R4 seed recurrence");
      send(M - 1, "R5 largest word");
      for (int i = 0; i < 20; i++) send(M - 1, "R6 carry chain on large words");
      send(0, "R4 zero word");
      idle(5);
      // R8 garbage offered with valid low must not disturb the sequence
      send(12345, "R8 after ignored inputs");
      for (int i = 0; i < 300; i++) begin
         send(int'($urandom % M), "R6 random stream");
         if ($urandom % 8 == 0) idle(int'($urandom % 4) + 1);
      end

      // R1 reset mid-stream restores seeds
      rst = 1'b1;
      in_data = W'($urandom);
      tick();
      rst = 1'b0;
      model_reset();
      check("R1 ready after mid reset", int'(in_ready), 1);
      check("R1 no strobe after mid reset", int'(out_valid), 0);
      send(0, "R1 seeds after mid reset");
      for (int i = 0; i < 50; i++) send(int'($urandom % M), "R9 in-range words");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule